// File: doc/BRIEF.md
# DMA Channel Programming and Interrupt Unit

This block is the register front end of a multichannel DMA controller. Software reaches it over a plain 32-bit register bus with separate write and read strobes. For each channel it holds a control word, a transfer count and three 64-bit addresses (source, destination and a stored chain pointer). All of these are presented in flattened form to the data-moving engine, which is outside the block. A control write that sets the enable bit produces a one-cycle start pulse for that channel. The unit also keeps a pending-abort flag for each channel, and the engine reads these flags.

The engine reports three kinds of event per channel: done, error and aborted. Each event sets a bit in a shared, packed status word and clears the enable bit of that channel. The single interrupt output stays high while at least one status bit is set whose event was unmasked at the moment it occurred. Software clears status bits by writing ones to them. Writing the global control register stops every channel at once.

Top module: `dmareg_top`

## Requirements
- R1: After reset, every channel register, the status word, the enable word, the pending-abort flags, the start pulses and the interrupt are zero. The configuration register at offset 0x10 reads the parameter CFG_VALUE, which defaults to 0xC3404108.
- R2: Channel n owns the 32-byte window starting at 0x40 + 0x20*n. Within that window, offsets +0x00, +0x04, +0x08, +0x0C, +0x10, +0x14, +0x18 and +0x1C hold, in that order, the control word, the transfer count, source low, source high, destination low, destination high, chain pointer low and chain pointer high. Each register reads back what was last written, and it also appears on the matching flattened output slice.
- R3: Reads of the global control (0x20) and abort (0x24) offsets return zero. So do reads of non-word-aligned or unmapped offsets, including 0x40 + 0x20*NCH and everything above it. Writes to the configuration (0x10) and enable-word (0x34) offsets change nothing.
- R4: Bit n of the word at 0x34 equals bit 0 (enable) of channel n's control word.
- R5: A control write whose bit 0 is 1 raises ch_start_o[n] in the cycle after the write, for exactly one cycle. Any other write leaves the start pulses low.
- R6: A write to 0x24 sets channel i's pending-abort flag only when data bit i is 1 and channel i is enabled. The flag clears on any event for channel i or on a global control write.
- R7: Any write to 0x20 clears the enable bit of every channel and every pending-abort flag. It leaves the rest of each control word as it was.
- R8: A done, abort or error event on channel n sets status bit 16+n, 8+n or n respectively, one cycle later. It also clears enable bit 0 of channel n.
- R9: Status at 0x30 is write-one-to-clear. If an event sets a bit in the same cycle that software clears it, the bit stays set.
- R10: irq_o is high exactly while some status bit is set whose event was unmasked when it occurred. Control bits 1, 2 and 3 mask done, error and abort events respectively. Changing a mask afterwards does not alter that bit's effect on irq_o.
- R11: When a control write and an event hit the same channel in the same cycle, the written control word is kept whole, including its enable bit, and the status bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid the following cycle |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_done | input | NCH | Per-channel transfer-complete event |
| evt_err | input | NCH | Per-channel error event |
| evt_abort | input | NCH | Per-channel abort-taken event |
| ch_ctrl_o | output | NCH*32 | Control words, channel n at [32n+:32] |
| ch_size_o | output | NCH*32 | Transfer counts |
| ch_src_o | output | NCH*64 | Source addresses |
| ch_dst_o | output | NCH*64 | Destination addresses |
| ch_link_o | output | NCH*64 | Stored chain pointers |
| ch_start_o | output | NCH | One-cycle start pulse per channel |
| ch_abort_pend_o | output | NCH | Pending-abort flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, NCH=8 and ADDR_W=9. With eight channels every lane of the three packed status groups is used, so an event on channel 7 exercises the top bit of each group. The 9-bit address reaches past the last window at 0x120–0x13F, so decoded channel numbers 8 to 15 can be driven and must read as unmapped. Random mixes of register writes, abort requests, events and clears are driven against a bench model. Directed cases cover clears and control writes that collide with events in the same cycle.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_CH    = 8;
  localparam int OFF_CFG   = 'h10;
  localparam int OFF_GCTL  = 'h20;
  localparam int OFF_ABT   = 'h24;
  localparam int OFF_IST   = 'h30;
  localparam int OFF_CEN   = 'h34;
  localparam int CH_BASE   = 'h40;
  localparam int CH_SHIFT  = 5;

  localparam int CTL_EN    = 0;
  localparam int CTL_MDONE = 1;
  localparam int CTL_MERR  = 2;
  localparam int CTL_MABT  = 3;

  typedef enum logic [2:0] {
    CR_CTRL = 3'd0,
    CR_SIZE = 3'd1,
    CR_SRCL = 3'd2,
    CR_SRCH = 3'd3,
    CR_DSTL = 3'd4,
    CR_DSTH = 3'd5,
    CR_LNKL = 3'd6,
    CR_LNKH = 3'd7
  } chreg_e;

  // done group at 16, abort group at 8, error group at 0
  function automatic logic [REG_W-1:0] ist_pack(input logic [MAX_CH-1:0] done,
                                                input logic [MAX_CH-1:0] abt,
                                                input logic [MAX_CH-1:0] err);
    return {8'h00, done, abt, err};
  endfunction
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 9,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cfg,
  output logic              hit_gctl,
  output logic              hit_abt,
  output logic              hit_ist,
  output logic              hit_cen,
  output logic              hit_ch,
  output logic [CHW-1:0]    ch_sel,
  output chreg_e            ch_reg
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(OFF_GCTL);
  localparam logic [ADDR_W-1:0] A_ABT  = ADDR_W'(OFF_ABT);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(OFF_IST);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(OFF_CEN);
  localparam logic [ADDR_W-1:0] A_CHB  = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] N_CH   = ADDR_W'(NCH);

  logic [ADDR_W-1:0] chn;

  always_comb begin
    chn      = (addr - A_CHB) >> CH_SHIFT;
    hit_cfg  = (addr == A_CFG);
    hit_gctl = (addr == A_GCTL);
    hit_abt  = (addr == A_ABT);
    hit_ist  = (addr == A_IST);
    hit_cen  = (addr == A_CEN);
    hit_ch   = (addr >= A_CHB) && (chn < N_CH) && (addr[1:0] == 2'b00);
    ch_sel   = chn[CHW-1:0];
    ch_reg   = chreg_e'(addr[4:2]);
  end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  chreg_e           sel_reg,
  input  logic [REG_W-1:0] wdata,
  input  logic             gclr,
  input  logic             evt_any,
  input  logic             abt_req,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] size_o,
  output logic [63:0]      src_o,
  output logic [63:0]      dst_o,
  output logic [63:0]      link_o,
  output logic             start_o,
  output logic             pend_o,
  output logic [REG_W-1:0] rd_data
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (sel_reg == CR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      size_o  <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      link_o  <= '0;
      start_o <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      start_o <= ctrl_wr && wdata[CTL_EN];
      if (ctrl_wr) ctrl_o <= wdata;
      else if (gclr || evt_any) ctrl_o[CTL_EN] <= 1'b0;
      if (wr_en) begin
        case (sel_reg)
          CR_SIZE: size_o         <= wdata;
          CR_SRCL: src_o[31:0]    <= wdata;
          CR_SRCH: src_o[63:32]   <= wdata;
          CR_DSTL: dst_o[31:0]    <= wdata;
          CR_DSTH: dst_o[63:32]   <= wdata;
          CR_LNKL: link_o[31:0]   <= wdata;
          CR_LNKH: link_o[63:32]  <= wdata;
          default: ;
        endcase
      end
      if (gclr || evt_any) pend_o <= 1'b0;
      else if (abt_req && ctrl_o[CTL_EN]) pend_o <= 1'b1;
    end
  end

  always_comb begin
    case (sel_reg)
      CR_CTRL: rd_data = ctrl_o;
      CR_SIZE: rd_data = size_o;
      CR_SRCL: rd_data = src_o[31:0];
      CR_SRCH: rd_data = src_o[63:32];
      CR_DSTL: rd_data = dst_o[31:0];
      CR_DSTH: rd_data = dst_o[63:32];
      CR_LNKL: rd_data = link_o[31:0];
      default: rd_data = link_o[63:32];
    endcase
  end
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq
  import dmareg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   evt_done,
  input  logic [NCH-1:0]   evt_err,
  input  logic [NCH-1:0]   evt_abort,
  input  logic [NCH-1:0]   mask_done,
  input  logic [NCH-1:0]   mask_err,
  input  logic [NCH-1:0]   mask_abt,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] clr_bits,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  logic [REG_W-1:0] set_v, arm_v, clr_v, live_q;

  always_comb begin
    set_v = ist_pack(MAX_CH'(evt_done), MAX_CH'(evt_abort), MAX_CH'(evt_err));
    arm_v = ist_pack(MAX_CH'(evt_done & ~mask_done),
                     MAX_CH'(evt_abort & ~mask_abt),
                     MAX_CH'(evt_err & ~mask_err));
    clr_v = clr_wr ? clr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      live_q   <= '0;
    end else begin
      status_o <= (status_o & ~clr_v) | set_v;
      live_q   <= (live_q & ~clr_v) | arm_v;
    end
  end

  assign irq_o = |(status_o & live_q);
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int               NCH       = 8,
  parameter int               ADDR_W    = 9,
  parameter logic [REG_W-1:0] CFG_VALUE = 32'hC340_4108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    evt_done,
  input  logic [NCH-1:0]    evt_err,
  input  logic [NCH-1:0]    evt_abort,
  output logic [NCH*32-1:0] ch_ctrl_o,
  output logic [NCH*32-1:0] ch_size_o,
  output logic [NCH*64-1:0] ch_src_o,
  output logic [NCH*64-1:0] ch_dst_o,
  output logic [NCH*64-1:0] ch_link_o,
  output logic [NCH-1:0]    ch_start_o,
  output logic [NCH-1:0]    ch_abort_pend_o,
  output logic              irq_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           hit_cfg, hit_gctl, hit_abt, hit_ist, hit_cen, hit_ch;
  logic [CHW-1:0] ch_sel;
  chreg_e         ch_reg;

  // named internal events, also used by the bound checker
  logic             gclr_wr, abt_wr, ist_wr;
  logic [NCH-1:0]   ch_wr, ch_en, ctrl_go, evt_any;
  logic [NCH-1:0]   mask_done, mask_err, mask_abt;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] ch_rd [NCH];
  logic [REG_W-1:0] rd_mux;

  dmareg_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .hit_cfg(hit_cfg), .hit_gctl(hit_gctl), .hit_abt(hit_abt),
    .hit_ist(hit_ist), .hit_cen(hit_cen), .hit_ch(hit_ch),
    .ch_sel(ch_sel), .ch_reg(ch_reg)
  );

  assign gclr_wr = reg_wr && hit_gctl;
  assign abt_wr  = reg_wr && hit_abt;
  assign ist_wr  = reg_wr && hit_ist;
  assign evt_any = evt_done | evt_err | evt_abort;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_wr[i]   = reg_wr && hit_ch && (ch_sel == CHW'(i));
    assign ctrl_go[i] = ch_wr[i] && (ch_reg == CR_CTRL) && reg_wdata[CTL_EN];

    dmareg_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ch_wr[i]), .sel_reg(ch_reg), .wdata(reg_wdata),
      .gclr(gclr_wr), .evt_any(evt_any[i]),
      .abt_req(abt_wr && reg_wdata[i]),
      .ctrl_o(ch_ctrl_o[i*32 +: 32]), .size_o(ch_size_o[i*32 +: 32]),
      .src_o(ch_src_o[i*64 +: 64]), .dst_o(ch_dst_o[i*64 +: 64]),
      .link_o(ch_link_o[i*64 +: 64]),
      .start_o(ch_start_o[i]), .pend_o(ch_abort_pend_o[i]),
      .rd_data(ch_rd[i])
    );

    assign ch_en[i]     = ch_ctrl_o[i*32 + CTL_EN];
    assign mask_done[i] = ch_ctrl_o[i*32 + CTL_MDONE];
    assign mask_err[i]  = ch_ctrl_o[i*32 + CTL_MERR];
    assign mask_abt[i]  = ch_ctrl_o[i*32 + CTL_MABT];
  end

  dmareg_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .evt_done(evt_done), .evt_err(evt_err), .evt_abort(evt_abort),
    .mask_done(mask_done), .mask_err(mask_err), .mask_abt(mask_abt),
    .clr_wr(ist_wr), .clr_bits(reg_wdata),
    .status_o(status_q), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_cfg)      rd_mux = CFG_VALUE;
    else if (hit_ist) rd_mux = status_q;
    else if (hit_cen) rd_mux = REG_W'(ch_en);
    else if (hit_ch)  rd_mux = ch_rd[ch_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dmareg_checker.sv
module dmareg_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gclr_wr,
  input logic           ist_wr,
  input logic [31:0]    wdata,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ctrl_go,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] evt_done,
  input logic [NCH-1:0] evt_err,
  input logic [NCH-1:0] evt_abort,
  input logic [31:0]    status,
  input logic           irq
);
  a_r7_gclr_stops_all: assert property (@(posedge clk) disable iff (!rst_n)
    gclr_wr |=> (ch_en == '0) && (pend == '0));

  a_r6_abort_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(ch_en)) == '0));

  a_r8_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_done) |=> ((status[16 +: NCH] & $past(evt_done)) == $past(evt_done)));

  a_r8_event_disables: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_err | evt_abort) != '0) && !(|ctrl_go)
      |=> ((ch_en & $past(evt_err | evt_abort)) == '0));

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start == $past(ctrl_go));

  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ist_wr && !(|evt_done) && !(|evt_err) && !(|evt_abort)
      |=> ((status & $past(wdata)) == '0));

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind dmareg_top dmareg_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .gclr_wr(gclr_wr), .ist_wr(ist_wr), .wdata(reg_wdata),
  .ch_en(ch_en), .ctrl_go(ctrl_go), .start(ch_start_o), .pend(ch_abort_pend_o),
  .evt_done(evt_done), .evt_err(evt_err), .evt_abort(evt_abort),
  .status(status_q), .irq(irq_o)
);

// File: tb/dmareg_top_bench.sv
`timescale 1ns/1ps
module dmareg_top_bench;
  localparam int NCH = 8;
  localparam logic [31:0] CFG = 32'hC340_4108;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] evt_done = '0, evt_err = '0, evt_abort = '0;
  logic [NCH*32-1:0] ch_ctrl_o, ch_size_o;
  logic [NCH*64-1:0] ch_src_o, ch_dst_o, ch_link_o;
  logic [NCH-1:0] ch_start_o, ch_abort_pend_o;
  logic irq_o;

  always #2 clk = ~clk;

  dmareg_top u_dmareg_top (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] m_reg [8][8];
  logic [31:0] m_st = '0, m_live = '0;
  logic [7:0]  m_pend = '0, m_start = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_en();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = m_reg[i][0][0];
    return e;
  endfunction

  function automatic logic [31:0] exp_read(input logic [8:0] a);
    logic [8:0] c;
    c = (a - 9'h40) >> 5;
    if (a == 9'h10) return CFG;
    if (a == 9'h30) return m_st;
    if (a == 9'h34) return {24'h0, m_en()};
    if (a >= 9'h40 && c < 9'd8 && a[1:0] == 2'b00) return m_reg[c[2:0]][a[4:2]];
    return 32'h0;
  endfunction

  // one bus cycle with optional write and engine events, model updated alongside
  task automatic step(input logic w, input logic [8:0] a, input logic [31:0] d,
                      input logic [7:0] tc, input logic [7:0] er, input logic [7:0] ab);
    logic [7:0] ev, en, ctl_wr;
    logic [31:0] setv, armv, clr;
    logic [8:0] c;
    logic gclr;
    ev = tc | er | ab;
    en = m_en();
    c = (a - 9'h40) >> 5;
    gclr = w && (a == 9'h20);
    setv = {8'h0, tc, ab, er};
    armv = '0;
    for (int i = 0; i < 8; i++) begin
      armv[16+i] = tc[i] & ~m_reg[i][0][1];
      armv[i]    = er[i] & ~m_reg[i][0][2];
      armv[8+i]  = ab[i] & ~m_reg[i][0][3];
    end
    clr = (w && a == 9'h30) ? d : 32'h0;
    m_st   = (m_st & ~clr) | setv;
    m_live = (m_live & ~clr) | armv;
    for (int i = 0; i < 8; i++) begin
      if (gclr || ev[i]) m_pend[i] = 1'b0;
      else if (w && a == 9'h24 && d[i] && en[i]) m_pend[i] = 1'b1;
    end
    ctl_wr = '0;
    if (w && a >= 9'h40 && c < 9'd8 && a[1:0] == 2'b00) begin
      m_reg[c[2:0]][a[4:2]] = d;
      if (a[4:2] == 3'd0) ctl_wr[c[2:0]] = 1'b1;
    end
    for (int i = 0; i < 8; i++)
      if ((gclr || ev[i]) && !ctl_wr[i]) m_reg[i][0][0] = 1'b0;
    m_start = '0;
    for (int i = 0; i < 8; i++) if (ctl_wr[i] && d[0]) m_start[i] = 1'b1;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    evt_done = tc; evt_err = er; evt_abort = ab;
    @(negedge clk);
    reg_wr = 1'b0; evt_done = '0; evt_err = '0; evt_abort = '0;
    chk("R5 start pulse", 64'(ch_start_o), 64'(m_start));
    chk("R6 pending abort", 64'(ch_abort_pend_o), 64'(m_pend));
    chk("R10 irq", 64'(irq_o), 64'(|(m_st & m_live)));
    m_start = '0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    step(1'b1, a, d, 8'h0, 8'h0, 8'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, 64'(reg_rdata), 64'(exp_read(a)));
  endtask

  function automatic logic [8:0] chaddr(input int ch, input int r);
    return 9'(32'h40 + ch * 32 + r * 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog actual=expired expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) for (int r = 0; r < 8; r++) m_reg[i][r] = '0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq at reset", 64'(irq_o), 64'd0);
    chk("R1 pend at reset", 64'(ch_abort_pend_o), 64'd0);
    chk("R1 ctrl outputs at reset", 64'(ch_ctrl_o[63:0]), 64'd0);
    rd_chk("R1 config value", 9'h10);
    chk("R1 config literal", 64'(reg_rdata), 64'(CFG));
    rd_chk("R1 status at reset", 9'h30);
    rd_chk("R1 enable word at reset", 9'h34);
    // R2 windows and flattened outputs
    wr(chaddr(7, 3), 32'hDEAD_BEEF);
    wr(chaddr(7, 2), 32'h1234_5678);
    wr(chaddr(0, 7), 32'hA5A5_0001);
    rd_chk("R2 ch7 src high", chaddr(7, 3));
    rd_chk("R2 ch0 link high", chaddr(0, 7));
    chk("R2 ch7 src output", ch_src_o[7*64 +: 64], 64'hDEAD_BEEF_1234_5678);
    chk("R2 ch0 link output", ch_link_o[63:0], 64'hA5A5_0001_0000_0000);
    // R3 read-only and unmapped
    wr(9'h10, 32'h0);
    wr(9'h34, 32'hFF);
    rd_chk("R3 config unchanged", 9'h10);
    rd_chk("R3 enable word unchanged", 9'h34);
    rd_chk("R3 global control reads zero", 9'h20);
    rd_chk("R3 abort reads zero", 9'h24);
    rd_chk("R3 unmapped 0x08", 9'h08);
    rd_chk("R3 beyond last window", 9'h140);
    rd_chk("R3 misaligned", chaddr(7, 3) | 9'h1);
    chk("R3 misaligned literal", 64'(reg_rdata), 64'd0);
    // R4/R5 enable channel 2
    wr(chaddr(2, 0), 32'h0000_0001);
    rd_chk("R4 enable word bit 2", 9'h34);
    chk("R4 enable literal", 64'(reg_rdata), 64'h4);
    // R6 abort to all, only ch2 enabled
    wr(9'h24, 32'hFF);
    chk("R6 only enabled channel", 64'(ch_abort_pend_o), 64'h4);
    // R8 done on ch2
    step(1'b0, 9'h0, 32'h0, 8'h04, 8'h0, 8'h0);
    rd_chk("R8 done bit 18", 9'h30);
    chk("R8 done literal", 64'(reg_rdata), 64'h0004_0000);
    rd_chk("R8 enable cleared", chaddr(2, 0));
    // R9 clear
    wr(9'h30, 32'h0004_0000);
    rd_chk("R9 cleared", 9'h30);
    // R10 masked done on ch3, later unmask
    wr(chaddr(3, 0), 32'h0000_0003);
    step(1'b0, 9'h0, 32'h0, 8'h08, 8'h0, 8'h0);
    chk("R10 masked event no irq", 64'(irq_o), 64'd0);
    wr(chaddr(3, 0), 32'h0000_0000);
    chk("R10 late unmask no irq", 64'(irq_o), 64'd0);
    // R8 error ch1 and abort ch7
    step(1'b0, 9'h0, 32'h0, 8'h0, 8'h02, 8'h80);
    rd_chk("R8 error and abort bits", 9'h30);
    chk("R8 err/abt literal", 64'(reg_rdata), 64'h0008_8002);
    // R9 collision: clear and set same bit
    step(1'b1, 9'h30, 32'h0000_0002, 8'h0, 8'h02, 8'h0);
    rd_chk("R9 set wins over clear", 9'h30);
    // R11 control write meets event on ch4
    step(1'b1, chaddr(4, 0), 32'h0000_0011, 8'h10, 8'h0, 8'h0);
    rd_chk("R11 written control kept", chaddr(4, 0));
    chk("R11 literal", 64'(ch_ctrl_o[4*32 +: 32]), 64'h11);
    // R7 global control
    wr(chaddr(5, 0), 32'h0000_00F1);
    wr(9'h24, 32'h20);
    wr(9'h20, 32'h0);
    rd_chk("R7 enable word zero", 9'h34);
    rd_chk("R7 control rest kept", chaddr(5, 0));
    chk("R7 literal", 64'(ch_ctrl_o[5*32 +: 32]), 64'hF0);
    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: wr(chaddr($urandom_range(0, 7), $urandom_range(0, 7)), $urandom);
        3: wr(chaddr($urandom_range(0, 7), 0), $urandom | 32'h1);
        4: wr(9'h24, $urandom);
        5: step(1'b0, 9'h0, 32'h0, 8'($urandom & $urandom), 8'($urandom & $urandom),
                8'($urandom & $urandom));
        6: step(1'b1, 9'h30, $urandom, 8'($urandom & $urandom), 8'($urandom & $urandom),
                8'($urandom & $urandom));
        7: rd_chk("R2 random read", 9'($urandom));
        8: step(1'b1, chaddr($urandom_range(0, 7), 0), $urandom, 8'($urandom & $urandom),
                8'h0, 8'($urandom & $urandom));
        default: if ($urandom_range(0, 3) == 0) wr(9'h20, $urandom);
                 else rd_chk("R8 random status", 9'h30);
      endcase
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) rd_chk("R2 final sweep", chaddr(c, r));
    rd_chk("R4 final enable word", 9'h34);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule